// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is a synthesizable I2C target that behaves like a small serial EEPROM. It holds 128 bytes in an internal register array. It oversamples the SCL and SDA lines on the system clock and pulls SDA low through an open-drain enable output. A host addresses the block with a device byte. That byte carries a fixed 4-bit prefix, three bits that must match strap inputs, and a read/write flag. After that, the host can write single bytes or up to a full 8-byte row, and it can read from the current pointer, from a chosen address, or as a continuous stream.

Write data is first collected in a row buffer. The bytes move into the array only when a stop condition ends the write. This commit starts a self-timed busy window of a programmable number of clocks. During that window the target does not respond to the bus, so a host learns that the write has finished by sending device bytes until one is acknowledged. The word address pointer keeps its value between transactions, and every current-address read is based on it.

Top module: `i2cee_target`

## Requirements
- R1: After reset the SDA pull-down enable and the busy output are both low.
- R2: A device byte, sent MSB first after a start, is accepted when bits 7..4 equal 1010 and bits 3..1 equal `strap_i`. Bit 0 equal to 1 selects a read and 0 selects a write. On acceptance the target holds SDA low for the ninth clock.
- R3: A device byte with the wrong prefix or the wrong strap bits gets no acknowledge. The target then ignores the bus until the next start.
- R4: In a write, the byte after the device byte is the word address, and only its low 7 bits are used. The target acknowledges that byte and every data byte after it by holding SDA low.
- R5: Each data byte goes to the current pointer. After each byte only pointer bits 2..0 increment, wrapping inside the 8-byte row, so a ninth byte overwrites the first.
- R6: A stop after at least one data byte commits the buffered row to the array. It also raises `busy_o` for exactly `TWR_CYCLES` clocks.
- R7: While `busy_o` is high the target acknowledges no device byte. Once it falls, a device byte is acknowledged again.
- R8: A write ended by a repeated start instead of a stop is discarded and `busy_o` stays low. The word address it carried still becomes the pointer.
- R9: A write device byte and a word address, followed by a repeated start and a read device byte, return the byte stored at that word address.
- R10: A read that starts with a read device byte returns the byte at the pointer. The pointer is one past the last byte accessed, and it keeps its value across transactions.
- R11: In a read, a host acknowledge after a byte makes the target send the next byte. The read pointer wraps from address 127 to address 0.
- R12: After a host non-acknowledge the target stops driving SDA and stays silent until the next start. A stop returns it to idle.
- R13: The target changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sampled I2C clock line |
| sda_i | input | 1 | Sampled I2C data line (resolved bus level) |
| strap_i | input | 3 | Hard-wired device address bits compared with device byte bits 3..1 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| busy_o | output | 1 | High while the self-timed write cycle runs |

## Verification
The assertions assume that SCL stays at one level for several system clocks around each edge, longer than the synchronizer and edge-detection delay. Under that assumption the target's registered SDA updates always land while SCL is low. The assertions also assume that SDA changes only while SCL is low, except at start and stop conditions. The bench host bit-bangs the bus with quarter-bit phases of eight clocks, and it moves SDA only in the middle of the low phase or during a deliberate start or stop. It resolves the open-drain line as the AND of the host level and the inverted target enable. The write-cycle length is set well above the eight-clock commit, so the commit always ends inside the busy window.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
  localparam int         BYTE_BITS  = 8;

endpackage

// File: rtl/i2cee_line_sync.sv
module i2cee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_sr;
  logic [STAGES-1:0] sda_sr;
  logic              scl_now;
  logic              sda_now;
  logic              scl_d;
  logic              sda_d;

  assign scl_now = scl_sr[STAGES-1];
  assign sda_now = sda_sr[STAGES-1];
  assign scl_lvl = scl_d;
  assign sda_lvl = sda_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sr    <= '1;
      sda_sr    <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_sr    <= {scl_sr[STAGES-2:0], scl_i};
      sda_sr    <= {sda_sr[STAGES-2:0], sda_i};
      scl_d     <= scl_now;
      sda_d     <= sda_now;
      scl_rise  <= scl_now & ~scl_d;
      scl_fall  <= ~scl_now & scl_d;
      start_det <= scl_now & scl_d & sda_d & ~sda_now;
      stop_det  <= scl_now & scl_d & ~sda_d & sda_now;
    end
  end

  // An SCL edge and a start/stop cannot be reported in the same cycle.
  assert_edge_vs_cond_R2: assert property (@(posedge clk) disable iff (rst)
    (scl_rise || scl_fall) |-> !(start_det || stop_det));

endmodule

// File: rtl/i2cee_store.sv
module i2cee_store #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/i2cee_page_buf.sv
module i2cee_page_buf #(
  parameter int PAGE_W = 3,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wofs,
  input  logic [DW-1:0]     wdata,
  input  logic [PAGE_W-1:0] rofs,
  output logic [DW-1:0]     rdata,
  output logic [(1<<PAGE_W)-1:0] valid
);

  localparam int ENTRIES = 1 << PAGE_W;

  logic [DW-1:0] slot [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        valid[i] <= 1'b0;
      end else if (wr && wofs == PAGE_W'(i)) begin
        valid[i] <= 1'b1;
      end
      if (wr && wofs == PAGE_W'(i)) slot[i] <= wdata;
    end
  end

  assign rdata = slot[rofs];

  // A discard/commit clear never coincides with loading a new byte.
  assert_clr_load_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(clr && wr));

endmodule

// File: rtl/i2cee_target.sv
module i2cee_target #(
  parameter int MEM_AW      = 7,
  parameter int PAGE_W      = 3,
  parameter int TWR_CYCLES  = 400,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  import i2cee_pkg::*;

  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int TMR_W      = $clog2(TWR_CYCLES + 1);
  localparam logic [PAGE_W-1:0] LAST_OFS = PAGE_W'(PAGE_BYTES - 1);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

  i2cee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  tgt_state_e        state;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg;
  logic [6:0]        txbits;
  logic              rw_bit;
  logic              host_ack;
  logic              oe_q;
  logic [MEM_AW-1:0] addr_ptr;
  logic              busy_q;
  logic [TMR_W-1:0]  tmr;
  logic              commit_act;
  logic [PAGE_W-1:0] commit_idx;

  logic [7:0]            rd_q;
  logic [7:0]            pb_rdata;
  logic [PAGE_BYTES-1:0] pb_valid;
  logic                  pb_wr, pb_clr, mem_we, commit_go, byte_done, dev_match;

  assign byte_done = scl_fall && (bitcnt == 4'd8);
  assign dev_match = (shreg[7:4] == DEV_PREFIX) && (shreg[3:1] == strap_i);
  assign pb_wr     = !busy_q && !stop_det && !start_det &&
                     (state == ST_WDATA) && byte_done;
  assign commit_go = !busy_q && stop_det && (|pb_valid) &&
                     ((state == ST_WDATA) || (state == ST_WDATA_ACK));
  assign pb_clr    = (commit_act && commit_idx == LAST_OFS) ||
                     (start_det && !busy_q);
  assign mem_we    = commit_act && pb_valid[commit_idx];

  i2cee_page_buf #(.PAGE_W(PAGE_W), .DW(8)) u_pbuf (
    .clk(clk), .rst(rst), .clr(pb_clr), .wr(pb_wr),
    .wofs(addr_ptr[PAGE_W-1:0]), .wdata(shreg),
    .rofs(commit_idx), .rdata(pb_rdata), .valid(pb_valid)
  );

  i2cee_store #(.AW(MEM_AW), .DW(8)) u_store (
    .clk(clk), .we(mem_we),
    .waddr({addr_ptr[MEM_AW-1:PAGE_W], commit_idx}), .wdata(pb_rdata),
    .raddr(addr_ptr), .rdata(rd_q)
  );

  // Self-timed write cycle: commit runs during the first PAGE_BYTES clocks.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      tmr        <= '0;
      commit_act <= 1'b0;
      commit_idx <= '0;
    end else if (busy_q) begin
      if (tmr == '0) busy_q <= 1'b0;
      else           tmr    <= tmr - 1'b1;
      if (commit_act) begin
        commit_idx <= commit_idx + 1'b1;
        if (commit_idx == LAST_OFS) commit_act <= 1'b0;
      end
    end else if (commit_go) begin
      busy_q     <= 1'b1;
      tmr        <= TMR_W'(TWR_CYCLES - 1);
      commit_act <= 1'b1;
      commit_idx <= '0;
    end
  end

  // Bus protocol engine.
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txbits   <= '0;
      rw_bit   <= 1'b0;
      host_ack <= 1'b0;
      oe_q     <= 1'b0;
      addr_ptr <= '0;
    end else if (busy_q) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (stop_det) begin
      state <= ST_IDLE;
      oe_q  <= 1'b0;
    end else if (start_det) begin
      state  <= ST_DEV;
      bitcnt <= '0;
      oe_q   <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WADDR, ST_WDATA: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_done) begin
            if (state == ST_DEV) begin
              if (dev_match) begin
                rw_bit <= shreg[0];
                oe_q   <= 1'b1;
                state  <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WADDR) begin
              addr_ptr <= shreg[MEM_AW-1:0];
              oe_q     <= 1'b1;
              state    <= ST_WADDR_ACK;
            end else begin
              addr_ptr <= {addr_ptr[MEM_AW-1:PAGE_W],
                           addr_ptr[PAGE_W-1:0] + 1'b1};
              oe_q     <= 1'b1;
              state    <= ST_WDATA_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw_bit) begin
              txbits   <= rd_q[6:0];
              oe_q     <= ~rd_q[7];
              addr_ptr <= addr_ptr + 1'b1;
              state    <= ST_RDATA;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_WADDR;
            end
          end
        end
        ST_WADDR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            oe_q   <= 1'b0;
            bitcnt <= '0;
            state  <= ST_WDATA;
          end
        end
        ST_RDATA: begin
          if (scl_rise && bitcnt < 4'd8) bitcnt <= bitcnt + 1'b1;
          if (scl_fall) begin
            if (bitcnt == 4'd8) begin
              oe_q   <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RACK;
            end else begin
              oe_q   <= ~txbits[6];
              txbits <= {txbits[5:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) host_ack <= ~sda_lvl;
          if (scl_fall) begin
            if (host_ack) begin
              txbits   <= rd_q[6:0];
              oe_q     <= ~rd_q[7];
              addr_ptr <= addr_ptr + 1'b1;
              bitcnt   <= '0;
              state    <= ST_RDATA;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: begin
          oe_q <= 1'b0;
        end
      endcase
    end
  end

  assign sda_oe_o = oe_q;
  assign busy_o   = busy_q;

  assert_busy_silent_R7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !oe_q);

  assert_drive_scl_low_R13: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> !scl_lvl);

  assert_commit_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy_q);

  assert_stop_idle_R12: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !busy_q) |=> (state == ST_IDLE) && !oe_q);

  assert_no_ack_mismatch_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEV && byte_done && !dev_match && !busy_q && !stop_det &&
     !start_det) |=> !oe_q);

endmodule

// File: tb/sim_i2cee_target.sv
`timescale 1ns/1ps
module sim_i2cee_target;

  localparam int TWR = 400;
  localparam int QW  = 8;

  typedef struct {
    string tag;
    int    val;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_scl = 1'b1;
  logic host_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  logic sda_oe, busy;
  wire  sda_line = host_sda & ~sda_oe;

  int n_checks = 0;
  int n_fail   = 0;
  int busy_cnt = 0;
  int obs_val;
  event obs_ev;
  item_t exp_q[$];

  always #2.5 clk = ~clk;

  i2cee_target #(.MEM_AW(7), .PAGE_W(3), .TWR_CYCLES(TWR), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .scl_i(host_scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  always @(negedge clk) if (busy) busy_cnt++;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: compares each observation with the oldest expectation.
  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        check("unexpected", obs_val, -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        check(it.tag, obs_val, it.val);
      end
    end
  end

  task automatic qw();
    repeat (QW) @(negedge clk);
  endtask

  task automatic bus_start();
    host_sda = 1'b1; qw();
    host_scl = 1'b1; qw();
    host_sda = 1'b0; qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; qw();
    host_scl = 1'b1; qw();
    host_sda = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    host_sda = b; qw();
    host_scl = 1'b1; qw(); qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic get_bit(output logic b);
    host_sda = 1'b1; qw();
    host_scl = 1'b1; qw();
    b = sda_line; qw();
    host_scl = 1'b0; qw();
  endtask

  task automatic tx(input logic [7:0] v, input string tag, input int exp_ack);
    logic a;
    exp_q.push_back('{tag, exp_ack});
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    get_bit(a);
    obs_val = int'(a);
    ->obs_ev;
  endtask

  task automatic rx(input logic nack, input string tag, input int exp_byte);
    logic [7:0] v;
    logic b;
    exp_q.push_back('{tag, exp_byte});
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    send_bit(nack);
    obs_val = int'(v);
    ->obs_ev;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    qw();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    qw();
    check("R1 oe after reset", int'(sda_oe), 0);
    check("R1 busy after reset", int'(busy), 0);

    // R3: wrong prefix, then a further byte also ignored
    bus_start();
    tx(8'h2A, "R3 bad prefix", 1);
    tx(8'hAA, "R3 ignored until start", 1);
    bus_stop();
    // R3: wrong strap bits
    bus_start();
    tx(8'hA6, "R3 strap mismatch", 1);
    bus_stop();

    // Byte write 0x12 <= 0xA5
    bus_start();
    tx(8'hAA, "R2 write addr ack", 0);
    tx(8'h12, "R4 word addr ack", 0);
    tx(8'hA5, "R4 data ack", 0);
    busy_cnt = 0;
    bus_stop();
    check("R6 busy after stop", int'(busy), 1);
    bus_start();
    tx(8'hAA, "R7 no ack while busy", 1);
    bus_stop();
    wait_idle();
    check("R6 busy length", busy_cnt, TWR);
    // R7 poll acked, R9 random read of 0x12
    bus_start();
    tx(8'hAA, "R7 ack after busy", 0);
    tx(8'h12, "R9 word addr", 0);
    bus_start();
    tx(8'hAB, "R9 read addr ack", 0);
    rx(1'b1, "R9 random read", 8'hA5);
    bus_stop();

    // R4: top word-address bit ignored, 0xA0 -> 0x20
    bus_start();
    tx(8'hAA, "R4 dev", 0);
    tx(8'hA0, "R4 word addr top bit", 0);
    tx(8'h3C, "R4 data", 0);
    bus_stop();
    wait_idle();

    // R5: ten bytes from 0x1E wrap inside row 0x18..0x1F
    bus_start();
    tx(8'hAA, "R5 dev", 0);
    tx(8'h1E, "R5 word addr", 0);
    for (int i = 0; i < 10; i++) tx(8'hD0 + 8'(i), "R5 page data ack", 0);
    bus_stop();
    wait_idle();
    bus_start();
    tx(8'hAA, "R11 dev", 0);
    tx(8'h18, "R11 word addr", 0);
    bus_start();
    tx(8'hAB, "R11 read dev", 0);
    for (int i = 0; i < 7; i++) rx(1'b0, "R5 R11 row contents", 8'hD2 + i);
    rx(1'b1, "R5 R11 row last", 8'hD9);
    bus_stop();

    // R10: current address read continues at 0x20
    bus_start();
    tx(8'hAB, "R10 read dev", 0);
    rx(1'b1, "R10 current address", 8'h3C);
    bus_stop();

    // R8: write cut by repeated start is dropped
    bus_start();
    tx(8'hAA, "R8 dev", 0);
    tx(8'h12, "R8 word addr", 0);
    tx(8'h77, "R8 data", 0);
    bus_start();
    check("R8 no busy on restart", int'(busy), 0);
    tx(8'hAA, "R8 dev again", 0);
    tx(8'h12, "R8 addr again", 0);
    bus_start();
    tx(8'hAB, "R8 read dev", 0);
    rx(1'b1, "R8 old data kept", 8'hA5);
    bus_stop();

    // R11 rollover 0x7F -> 0x00
    bus_start();
    tx(8'hAA, "R11 dev", 0);
    tx(8'h7F, "R11 addr", 0);
    tx(8'h11, "R11 data", 0);
    bus_stop();
    wait_idle();
    bus_start();
    tx(8'hAA, "R11 dev", 0);
    tx(8'h00, "R11 addr", 0);
    tx(8'h22, "R11 data", 0);
    bus_stop();
    wait_idle();
    bus_start();
    tx(8'hAA, "R11 dev", 0);
    tx(8'h7F, "R11 addr", 0);
    bus_start();
    tx(8'hAB, "R11 read dev", 0);
    rx(1'b0, "R11 byte 127", 8'h11);
    rx(1'b1, "R11 wrap to 0", 8'h22);
    // R12: silent after host non-acknowledge
    rx(1'b1, "R12 silent after nack", 8'hFF);
    check("R12 oe released", int'(sda_oe), 0);
    bus_stop();

    qw();
    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule